// File: doc/BRIEF.md
# Transition-Filtered Status Register Group

This block is one status group of an instrument's status reporting. It takes a vector of live condition signals, samples it once per clock, and compares each new sample with the one before it. Two programmable masks decide which transitions count. The rise mask selects bits whose 0-to-1 change is recorded, and the fall mask selects bits whose 1-to-0 change is recorded. Each recorded transition sets a sticky bit in the event register. An enable mask picks which event bits feed one summary output. A status-byte aggregator elsewhere places that output at bit 3.

Software reaches the group through a small register port. It can read the sampled condition, the event register and the three masks, and it can write the three masks. The other registers are read-only. A read of the event register returns its contents and clears it in the same clock edge. A transition that is recorded in that same edge survives the clear, so no event is lost. Reads answer one cycle after the request. A two-state sequencer, `ST_IDLE` and `ST_RESP`, produces that answer. The transition IDLE->RESP happens on a read request, RESP->RESP happens on a back-to-back read, and RESP->IDLE happens on any cycle without a read.

Top module: `status_event_group`

## Requirements
- R1: After reset the rise mask reads 0xFFFF, and the fall mask, the enable mask and the event register read 0. `summary` and `rd_valid` are low.
- R2: Selector 0 reads the condition inputs as sampled by one register stage. An input change at edge k is visible in reads issued after edge k.
- R3: A sampled 0-to-1 change of a bit whose rise mask bit (selector 1) is 1 sets that event bit at the following edge. If the rise mask bit is 0, the change sets nothing.
- R4: A sampled 1-to-0 change of a bit whose fall mask bit (selector 2) is 1 sets that event bit at the following edge. If the fall mask bit is 0, the change sets nothing.
- R5: An event bit stays set after its condition returns. Only a read of the event register clears it.
- R6: A read of selector 3 returns the event register and clears it. A transition recorded at that same edge stays set.
- R7: `summary` is high exactly when some event bit and the same bit of the enable mask (selector 4) are both 1.
- R8: Writes to selectors 1, 2 and 4 are read back unchanged. Writes to selectors 0, 3 and 5..7 change no register, and reads of selectors 5..7 return 0.
- R9: A read request raises `rd_valid` for the next cycle, with `rd_data` holding the value at the request edge. `rd_valid` stays high for back-to-back reads and falls after the first cycle without a read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cond_in | input | 16 | Live condition signals |
| acc_valid | input | 1 | Register access request |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_sel | input | 3 | Register selector: 0 cond, 1 rise mask, 2 fall mask, 3 event, 4 enable |
| acc_wdata | input | 16 | Write data |
| rd_valid | output | 1 | Read data valid, one cycle after the request |
| rd_data | output | 16 | Read data |
| summary | output | 1 | OR of enabled event bits (status byte bit 3) |

## Verification
The hardest case to reach from the ports is a clear-on-read of the event register in the same edge that records a new transition. The two must coincide to the cycle, with the condition sample already one stage old. A directed sequence first toggles the input one cycle ahead of the read, so that the edge is detected exactly at the read's edge. It then reads again to confirm that the new bit survived and the older bits did not. Random rounds with a fixed seed then vary inputs, masks, selectors and writes. A bench model of the masks and the event register tracks every cycle.

// File: rtl/stsgrp_pkg.sv
package stsgrp_pkg;
    localparam int unsigned STS_W   = 16;
    localparam int unsigned SEL_W   = 3;

    typedef enum logic [SEL_W-1:0] {
        SEL_COND  = 3'd0,
        SEL_RISE  = 3'd1,
        SEL_FALL  = 3'd2,
        SEL_EVENT = 3'd3,
        SEL_MASK  = 3'd4
    } reg_sel_e;

    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_RESP = 1'b1
    } acc_state_e;
endpackage

// File: rtl/stsgrp_sampler.sv
module stsgrp_sampler #(
    parameter int unsigned W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] cond_in,
    output logic [W-1:0] cond_q,
    output logic [W-1:0] prev_q,
    output logic [W-1:0] rise,
    output logic [W-1:0] fall
);
    // one sampling stage, then one history stage for edge detection
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cond_q <= '0;
            prev_q <= '0;
        end else begin
            cond_q <= cond_in;
            prev_q <= cond_q;
        end
    end

    always_comb begin
        rise = cond_q & ~prev_q;
        fall = ~cond_q & prev_q;
    end
endmodule

// File: rtl/stsgrp_latch.sv
module stsgrp_latch #(
    parameter int unsigned W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] rise,
    input  logic [W-1:0] fall,
    input  logic [W-1:0] rise_mask,
    input  logic [W-1:0] fall_mask,
    input  logic         clr,
    output logic [W-1:0] event_q
);
    for (genvar b = 0; b < W; b++) begin : g_bit
        logic hit;
        assign hit = (rise[b] & rise_mask[b]) | (fall[b] & fall_mask[b]);

        // a new hit wins over the clear so no transition is lost
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                event_q[b] <= 1'b0;
            else if (hit)
                event_q[b] <= 1'b1;
            else if (clr)
                event_q[b] <= 1'b0;
        end
    end
endmodule

// File: rtl/stsgrp_access.sv
module stsgrp_access
    import stsgrp_pkg::*;
#(
    parameter int unsigned W      = 16,
    parameter int unsigned SW     = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          acc_valid,
    input  logic          acc_write,
    input  logic [SW-1:0] acc_sel,
    input  logic [W-1:0]  acc_wdata,
    input  logic [W-1:0]  cond_q,
    input  logic [W-1:0]  event_q,
    output logic [W-1:0]  rise_mask,
    output logic [W-1:0]  fall_mask,
    output logic [W-1:0]  en_mask,
    output logic          clr_event,
    output logic          rd_valid,
    output logic [W-1:0]  rd_data
);
    localparam logic [W-1:0] RISE_RST = {W{1'b1}};

    acc_state_e state_q, state_d;
    logic       rd_req, wr_req;
    logic [W-1:0] rd_mux;

    assign rd_req    = acc_valid && !acc_write;
    assign wr_req    = acc_valid &&  acc_write;
    assign clr_event = rd_req && (acc_sel == SW'(SEL_EVENT));

    always_comb begin
        unique case (acc_sel)
            SW'(SEL_COND):  rd_mux = cond_q;
            SW'(SEL_RISE):  rd_mux = rise_mask;
            SW'(SEL_FALL):  rd_mux = fall_mask;
            SW'(SEL_EVENT): rd_mux = event_q;
            SW'(SEL_MASK):  rd_mux = en_mask;
            default:        rd_mux = '0;
        endcase
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (rd_req)  state_d = ST_RESP;
            ST_RESP: if (!rd_req) state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // state register and read data capture
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            rd_data <= '0;
        end else begin
            state_q <= state_d;
            if (rd_req)
                rd_data <= rd_mux;
        end
    end

    // output process
    always_comb begin
        unique case (state_q)
            ST_RESP: rd_valid = 1'b1;
            default: rd_valid = 1'b0;
        endcase
    end

    // writable masks
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rise_mask <= RISE_RST;
            fall_mask <= '0;
            en_mask   <= '0;
        end else if (wr_req) begin
            unique case (acc_sel)
                SW'(SEL_RISE): rise_mask <= acc_wdata;
                SW'(SEL_FALL): fall_mask <= acc_wdata;
                SW'(SEL_MASK): en_mask   <= acc_wdata;
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/status_event_group.sv
module status_event_group
    import stsgrp_pkg::*;
#(
    parameter int unsigned W  = STS_W,
    parameter int unsigned SW = SEL_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [W-1:0]  cond_in,
    input  logic          acc_valid,
    input  logic          acc_write,
    input  logic [SW-1:0] acc_sel,
    input  logic [W-1:0]  acc_wdata,
    output logic          rd_valid,
    output logic [W-1:0]  rd_data,
    output logic          summary
);
    logic [W-1:0] cond_q, prev_q, rise, fall;
    logic [W-1:0] rise_mask, fall_mask, en_mask, event_q;
    logic         clr_event;

    stsgrp_sampler #(.W(W)) u_sampler (
        .clk     (clk),
        .rst_n   (rst_n),
        .cond_in (cond_in),
        .cond_q  (cond_q),
        .prev_q  (prev_q),
        .rise    (rise),
        .fall    (fall)
    );

    stsgrp_latch #(.W(W)) u_latch (
        .clk       (clk),
        .rst_n     (rst_n),
        .rise      (rise),
        .fall      (fall),
        .rise_mask (rise_mask),
        .fall_mask (fall_mask),
        .clr       (clr_event),
        .event_q   (event_q)
    );

    stsgrp_access #(.W(W), .SW(SW)) u_access (
        .clk       (clk),
        .rst_n     (rst_n),
        .acc_valid (acc_valid),
        .acc_write (acc_write),
        .acc_sel   (acc_sel),
        .acc_wdata (acc_wdata),
        .cond_q    (cond_q),
        .event_q   (event_q),
        .rise_mask (rise_mask),
        .fall_mask (fall_mask),
        .en_mask   (en_mask),
        .clr_event (clr_event),
        .rd_valid  (rd_valid),
        .rd_data   (rd_data)
    );

    assign summary = |(event_q & en_mask);
endmodule

// File: rtl/status_event_group_chk.sv
module status_event_group_chk #(
    parameter int unsigned W  = 16,
    parameter int unsigned SW = 3
) (
    input logic          clk,
    input logic          rst_n,
    input logic          acc_valid,
    input logic          acc_write,
    input logic [SW-1:0] acc_sel,
    input logic          rd_valid,
    input logic [W-1:0]  rd_data,
    input logic          summary,
    input logic [W-1:0]  cond_q,
    input logic [W-1:0]  prev_q,
    input logic [W-1:0]  event_q,
    input logic [W-1:0]  en_mask
);
    logic rd_req, evt_rd;
    assign rd_req = acc_valid && !acc_write;
    assign evt_rd = rd_req && (acc_sel == SW'(3));

    a_r9_resp_follows: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req |=> rd_valid);

    a_r9_resp_ends: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_req |=> !rd_valid);

    // R5: without an event read, no event bit may drop
    a_r5_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        !evt_rd |=> ((event_q & $past(event_q)) == $past(event_q)));

    // R3/R4: a newly set bit needs a sampled change of that bit
    a_r3_needs_edge: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((event_q & ~$past(event_q) & ~($past(cond_q) ^ $past(prev_q))) == '0));

    a_r6_read_value: assert property (@(posedge clk) disable iff (!rst_n)
        evt_rd |=> (rd_data == $past(event_q)));

    a_r7_masked_off: assert property (@(posedge clk) disable iff (!rst_n)
        (en_mask == '0) |-> !summary);
endmodule

bind status_event_group status_event_group_chk #(.W(W), .SW(SW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .acc_valid (acc_valid),
    .acc_write (acc_write),
    .acc_sel   (acc_sel),
    .rd_valid  (rd_valid),
    .rd_data   (rd_data),
    .summary   (summary),
    .cond_q    (cond_q),
    .prev_q    (prev_q),
    .event_q   (event_q),
    .en_mask   (en_mask)
);

// File: tb/status_event_group_test.sv
module status_event_group_test;
    localparam int CLK_PERIOD = 10;
    localparam int W = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [W-1:0]  cond_in = '0;
    logic          acc_valid = 1'b0;
    logic          acc_write = 1'b0;
    logic [2:0]    acc_sel = '0;
    logic [W-1:0]  acc_wdata = '0;
    logic          rd_valid;
    logic [W-1:0]  rd_data;
    logic          summary;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // bench model
    logic [W-1:0] m_cond, m_prev, m_ev, m_rise, m_fall, m_en, m_rdata;
    logic         m_rdv;

    status_event_group uut (
        .clk(clk), .rst_n(rst_n), .cond_in(cond_in),
        .acc_valid(acc_valid), .acc_write(acc_write), .acc_sel(acc_sel),
        .acc_wdata(acc_wdata), .rd_valid(rd_valid), .rd_data(rd_data),
        .summary(summary)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(string req, logic [W-1:0] act, logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [W-1:0] sel_value(logic [2:0] s);
        case (s)
            3'd0: return m_cond;
            3'd1: return m_rise;
            3'd2: return m_fall;
            3'd3: return m_ev;
            3'd4: return m_en;
            default: return '0;
        endcase
    endfunction

    function automatic string sel_req(logic [2:0] s);
        case (s)
            3'd0: return "R2";
            3'd3: return "R6";
            default: return "R8";
        endcase
    endfunction

    function automatic logic [W-1:0] new_hits();
        return (m_cond & ~m_prev & m_rise) | (~m_cond & m_prev & m_fall);
    endfunction

    // inputs are already set (at negedge); advance one edge, update model, check
    task automatic tick();
        logic [W-1:0] n_ev;
        logic rd;
        logic [2:0] s;
        rd = acc_valid && !acc_write;
        s  = acc_sel;
        n_ev = ((rd && s == 3'd3) ? '0 : m_ev) | new_hits();
        if (rd) m_rdata = sel_value(s);
        m_rdv = rd;
        if (acc_valid && acc_write) begin
            if (s == 3'd1) m_rise = acc_wdata;
            if (s == 3'd2) m_fall = acc_wdata;
            if (s == 3'd4) m_en   = acc_wdata;
        end
        m_prev = m_cond;
        m_cond = cond_in;
        m_ev   = n_ev;
        @(posedge clk);
        #1;
        check("R9", {15'd0, rd_valid}, {15'd0, m_rdv});
        if (m_rdv) check(sel_req(s), rd_data, m_rdata);
        check("R7", {15'd0, summary}, {15'd0, |(m_ev & m_en)});
        @(negedge clk);
        acc_valid = 1'b0;
    endtask

    task automatic do_read(logic [2:0] s);
        acc_valid = 1'b1; acc_write = 1'b0; acc_sel = s;
        tick();
    endtask

    task automatic do_write(logic [2:0] s, logic [W-1:0] d);
        acc_valid = 1'b1; acc_write = 1'b1; acc_sel = s; acc_wdata = d;
        tick();
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4242));
        m_cond = '0; m_prev = '0; m_ev = '0; m_rise = '1; m_fall = '0;
        m_en = '0; m_rdata = '0; m_rdv = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1: reset state
        check("R1 rd_valid", {15'd0, rd_valid}, '0);
        check("R1 summary", {15'd0, summary}, '0);
        do_read(3'd1); check("R1 rise mask", rd_data, 16'hFFFF);
        do_read(3'd2); check("R1 fall mask", rd_data, 16'h0000);
        do_read(3'd4); check("R1 enable", rd_data, 16'h0000);
        do_read(3'd3); check("R1 event", rd_data, 16'h0000);
        tick();

        // R3: rising edge, masked vs unmasked
        do_write(3'd1, 16'h0001);
        cond_in = 16'h0003; tick(); tick();
        do_read(3'd3); check("R3 only bit0 latched", rd_data, 16'h0001);
        // R4: falling edge on bit1 with fall mask
        do_write(3'd2, 16'h0002);
        cond_in = 16'h0000; tick(); tick();
        do_read(3'd3); check("R4 only bit1 latched", rd_data, 16'h0002);
        // R5: sticky after condition returns
        cond_in = 16'h0001; tick(); cond_in = 16'h0000; tick(); tick(); tick();
        do_read(3'd3); check("R5 sticky bit0", rd_data, 16'h0001);
        // R6: edge coincides with clear-on-read
        cond_in = 16'h0001; tick(); tick();          // bit0 event set
        cond_in = 16'h0000; tick();                  // cond_q falls at this edge
        cond_in = 16'h0001; tick();                  // prev=1 cond=0 -> bit1? no, fall mask bit1 only
        // now cond_q=1, prev=0: rising bit0 detected at the read's edge
        do_read(3'd3); check("R6 read returns old event", rd_data, 16'h0001);
        do_read(3'd3); check("R6 coincident edge kept", rd_data, 16'h0001);
        do_read(3'd3); check("R6 cleared after read", rd_data, 16'h0000);
        // R8: writes to read-only and unused selectors ignored
        do_write(3'd0, 16'hABCD); do_write(3'd3, 16'hFFFF); do_write(3'd6, 16'h1234);
        do_read(3'd3); check("R8 event unchanged", rd_data, 16'h0000);
        do_read(3'd5); check("R8 unused reads 0", rd_data, 16'h0000);
        // R7: summary via enable
        do_write(3'd4, 16'h0001);
        cond_in = 16'h0000; tick(); tick();
        cond_in = 16'h0001; tick(); tick();
        check("R7 summary high", {15'd0, summary}, 16'h0001);
        // R9: back-to-back reads then idle
        do_read(3'd0); do_read(3'd0); tick();
        check("R9 rd_valid low after idle", {15'd0, rd_valid}, '0);

        // random rounds
        for (int i = 0; i < 3000; i++) begin
            if (($urandom % 4) == 0) cond_in = W'($urandom);
            if (($urandom % 3) == 0) begin
                acc_valid = 1'b1;
                acc_write = (($urandom % 3) == 0);
                acc_sel   = 3'($urandom);
                acc_wdata = W'($urandom);
            end
            tick();
        end

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule